// File: doc/BRIEF.md
# Switch-Hex / Decade-Count Single-Digit Display Controller

This block drives one seven-segment digit and four indicator LEDs from a small set of board controls. With the mode button released, the digit shows the 4-bit switch value as a hexadecimal character. With the mode button held, the digit shows a decimal counter that runs through 0 to 9 and then starts again. The four LEDs always show that counter in binary, so they agree with the digit whenever the mode button is held.

The counter steps once every `TICK_DIV` clock cycles. A prescaler produces that step, and the parameter can be made small for simulation. A clear button returns the counter to zero and also restarts the prescaler. Both buttons pass through a two-flop synchroniser before use. The switch bus goes straight to the decoder.

Top module: `segdemo_ctrl`

## Requirements
- R1: With the synchronised mode button low, `seg` shows the glyph for `sw`. Segments are active-high in the order `seg[6:0]` = {g,f,e,d,c,b,a}. The glyphs for 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C (lowercase b), 39, 5E (lowercase d), 79, 71 (hex).
- R2: With the synchronised mode button high, `seg` shows the R1 glyph of the counter value instead of the switch value.
- R3: `led` always equals the counter value in binary. While the mode button is held, this is the same value the digit shows.
- R4: The counter goes from 9 back to 0 and never takes a value from 10 to 15.
- R5: The counter advances by one every `TICK_DIV` clock cycles. After reset is released, the first step happens on the `TICK_DIV`-th rising edge.
- R6: While the synchronised clear button is high, the counter is forced to 0 at every edge.
- R7: Clearing also restarts the prescaler. The first step after a clear comes `TICK_DIV` edges after the last clearing edge.
- R8: The counter keeps running whatever the mode button does. Only the source of the digit changes.
- R9: Both buttons pass through two flip-flops. A change on a button pin takes effect on the second rising edge after it is driven, not on the first.
- R10: Reset is synchronous and active-low. An edge with `rst_n` low clears the counter, the prescaler and both synchronisers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw | input | 4 | Switch value shown in hex mode |
| btn_mode | input | 1 | Mode button, high while held (asynchronous) |
| btn_clr | input | 1 | Counter clear button, high while pressed (asynchronous) |
| seg | output | 7 | Segment lines {g,f,e,d,c,b,a}, active-high |
| led | output | 4 | Counter value in binary |

## Verification
The hardest case to reach is the prescaler restart after a clear. It can only be told apart from a plain counter reset by timing the first step after the clear button is released. That timing depends on the two synchroniser cycles at both the press and the release. The bench holds the clear button across several edges and counts the edges to the last one that still clears. It then checks that the LEDs stay at zero one edge before the full tick period has passed and change to one exactly at that period. Mode switching is probed on the first and second edges after each press and release, to pin down the two-flop latency.

// File: rtl/segdemo_pkg.sv
// Shared constants and the hex-to-segment glyph function.
// Assumes active-high segments packed as {g,f,e,d,c,b,a}.
package segdemo_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    // Map one hex digit to its segment pattern.
    function automatic logic [SEG_W-1:0] hex_glyph(input logic [DIGIT_W-1:0] v);
        logic [SEG_W-1:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/segdemo_sync.sv
// Multi-stage flip-flop synchroniser for a bus of independent level signals.
// Assumes each bit is a slow level (button); no bus coherency is implied.
module segdemo_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/segdemo_tick.sv
// Prescaler: pulses tick for one cycle every DIV clock cycles.
// Assumes DIV >= 1; clr restarts the period from zero.
module segdemo_tick #(
    parameter int DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    // Count cycles within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt <= '0;
        else if (tick)     pcnt <= '0;
        else               pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/segdemo_decade.sv
// Modulo-(LAST+1) counter stepped by adv and cleared by clr.
// Assumes LAST fits in WIDTH bits.
module segdemo_decade #(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(LAST);

    // Step the count, wrapping from TOP to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (adv)      count <= (count == TOP) ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/segdemo_hexseg.sv
// Combinational hex digit to seven-segment decoder.
// Assumes active-high segments {g,f,e,d,c,b,a}.
module segdemo_hexseg
    import segdemo_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit,
    output logic [SEG_W-1:0]   seg
);

    // Look up the glyph.
    always_comb seg = hex_glyph(digit);

endmodule

// File: rtl/segdemo_ctrl.sv
// Top level: switch-hex / decade-count single-digit display controller.
// Buttons are synchronised; the switch bus feeds the decoder directly.
// Assumes buttons are high while pressed and already debounced enough.
module segdemo_ctrl
    import segdemo_pkg::*;
#(
    parameter int TICK_DIV    = 25_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIGIT_W-1:0]  sw,
    input  logic                btn_mode,
    input  logic                btn_clr,
    output logic [SEG_W-1:0]    seg,
    output logic [DIGIT_W-1:0]  led
);

    localparam int COUNT_LAST = 9;

    logic [1:0]         btn_s;
    logic               mode_s;
    logic               clr_s;
    logic               tick;
    logic [DIGIT_W-1:0] count;
    logic [DIGIT_W-1:0] digit;

    segdemo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({btn_mode, btn_clr}),
        .q     (btn_s)
    );

    assign mode_s = btn_s[1];
    assign clr_s  = btn_s[0];

    segdemo_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_s),
        .tick  (tick)
    );

    segdemo_decade #(.WIDTH(DIGIT_W), .LAST(COUNT_LAST)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_s),
        .adv   (tick),
        .count (count)
    );

    // Pick the digit source from the held mode button.
    always_comb digit = mode_s ? count : sw;

    segdemo_hexseg u_hex (
        .digit (digit),
        .seg   (seg)
    );

    assign led = count;

endmodule

// File: rtl/segdemo_ctrl_chk.sv
// Property checker for segdemo_ctrl, attached with bind.
// Assumes the bound instance exposes mode_s, clr_s and tick.
module segdemo_ctrl_chk
    import segdemo_pkg::*;
#(
    parameter int TICK_DIV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DIGIT_W-1:0] sw,
    input logic [SEG_W-1:0]   seg,
    input logic [DIGIT_W-1:0] led,
    input logic               mode_s,
    input logic               clr_s,
    input logic               tick
);

    // R1
    hex_mode_glyph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |-> seg == hex_glyph(sw));

    // R2
    count_mode_glyph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |-> seg == hex_glyph(led));

    // R4
    led_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led <= 4'd9);

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led == 4'd9 && tick && !clr_s) |=> led == 4'd0);

    // R5
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_s) |=> $stable(led));

    // R6
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> led == 4'd0);

    // R7
    generate
        if (TICK_DIV > 1) begin : g_restart
            prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_s |=> !tick);
        end
    endgenerate

    // R10
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> led == 4'd0);

endmodule

bind segdemo_ctrl segdemo_ctrl_chk #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw     (sw),
    .seg    (seg),
    .led    (led),
    .mode_s (mode_s),
    .clr_s  (clr_s),
    .tick   (tick)
);

// File: tb/segdemo_ctrl_tb.sv
// Self-checking bench for segdemo_ctrl with a short tick period.
module segdemo_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = 4'h0;
    logic       btn_mode = 1'b0;
    logic       btn_clr = 1'b0;
    logic [6:0] seg;
    logic [3:0] led;

    int checks = 0;
    int errors = 0;
    int since  = 0;
    int max_led = 0;
    bit done = 1'b0;

    // {switch value, expected glyph} per R1
    localparam logic [10:0] VEC [16] = '{
        {4'h0, 7'h3F}, {4'h1, 7'h06}, {4'h2, 7'h5B}, {4'h3, 7'h4F},
        {4'h4, 7'h66}, {4'h5, 7'h6D}, {4'h6, 7'h7D}, {4'h7, 7'h07},
        {4'h8, 7'h7F}, {4'h9, 7'h6F}, {4'hA, 7'h77}, {4'hB, 7'h7C},
        {4'hC, 7'h39}, {4'hD, 7'h5E}, {4'hE, 7'h79}, {4'hF, 7'h71}
    };

    segdemo_ctrl #(.TICK_DIV(TDIV)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw       (sw),
        .btn_mode (btn_mode),
        .btn_clr  (btn_clr),
        .seg      (seg),
        .led      (led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_count();
        return (since / TDIV) % 10;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance n edges, then settle 2 time units; track counter model.
    task automatic step(input int n, input bit zero = 1'b0);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
            if (zero) since = 0;
            else      since++;
            if (int'(led) > max_led) max_led = int'(led);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        step(3);
        check("R10 led in reset", int'(led), 0);
        check("R10 seg in reset", int'(seg), int'(VEC[0][6:0]));

        // R1: glyph table, mode released
        for (int i = 0; i < 16; i++) begin
            sw = VEC[i][10:7];
            #1;
            check("R1 hex glyph", int'(seg), int'(VEC[i][6:0]));
        end
        sw = 4'h0;

        // Release reset right after an edge; count edges from here.
        rst_n = 1'b1;
        since = 0;
        step(TDIV - 1);
        check("R5 no step before period", int'(led), 0);
        step(1);
        check("R5 first step on period edge", int'(led), 1);
        step(39 - since);
        check("R3 led reaches nine", int'(led), 9);
        step(1);
        check("R4 wrap from nine", int'(led), 0);
        step(2 * TDIV + 1);
        check("R8 counting with mode released", int'(led), exp_count());

        // R9 / R2: mode press latency
        sw = 4'hA;
        btn_mode = 1'b1;
        step(1);
        check("R9 one edge still hex", int'(seg), int'(VEC[10][6:0]));
        step(1);
        check("R2 count glyph after two edges", int'(seg), int'(VEC[exp_count()][6:0]));
        check("R3 led matches model", int'(led), exp_count());
        step(TDIV);
        check("R8 counting with mode held", int'(led), exp_count());
        check("R3 digit matches led", int'(seg), int'(VEC[led][6:0]));
        btn_mode = 1'b0;
        step(1);
        check("R9 one edge still count", int'(seg), int'(VEC[exp_count()][6:0]));
        step(1);
        check("R1 hex glyph after release", int'(seg), int'(VEC[10][6:0]));

        // R6 / R7: clear held across several edges
        step(TDIV * 2);
        btn_clr = 1'b1;
        step(2);
        step(1, 1'b1);
        check("R6 cleared on third edge", int'(led), 0);
        step(2, 1'b1);
        check("R6 held at zero", int'(led), 0);
        btn_clr = 1'b0;
        step(2, 1'b1);
        check("R6 zero through release", int'(led), 0);
        step(TDIV - 1);
        check("R7 no early step after clear", int'(led), 0);
        step(1);
        check("R7 first step one period after clear", int'(led), 1);
        step(25);
        check("R3 led model after clear", int'(led), exp_count());

        // R4: never above nine over the whole run
        check("R4 max led seen", max_led, 9);

        // R10: reset mid-run
        rst_n = 1'b0;
        step(1, 1'b1);
        check("R10 reset clears counter", int'(led), 0);
        rst_n = 1'b1;
        step(TDIV);
        check("R10 prescaler cleared by reset", int'(led), 1);

        done = 1'b1;
        finish_run();
    end

endmodule